// File: doc/BRIEF.md
# Line test pattern generator

This block drives a fixed, repeatable test line onto up to four parallel pixel channels in place of live sensor samples. When the output mode selects test data, every channel walks through a 512-step sequence: a low ramp, a high ramp, then four short plateaus whose levels differ from channel to channel. The sequence starts again from its first step until the pixel budget for the line runs out. Each value is produced in 12-bit terms and shifted right to fit an 8-bit or 10-bit output when a narrower width is selected. In any other mode the registered sensor sample passes through unchanged.

A line begins with a one-cycle `line_start` pulse, which loads the number of pixels per channel and sends every channel back to step 0. After that, each cycle with `pix_adv` high produces one pixel per channel, until the budget is spent. The results appear on registered outputs one cycle after the advance. A downstream formatter only has to watch `pix_valid`.

Top module: `tpg_line`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `pix_valid` is 0 and `pix_data` is all zeros.
- R2: A `line_start` pulse loads `pix_count`. Afterwards, exactly `pix_count` cycles with `pix_adv` high each produce one pixel. Cycles with `pix_adv` low consume nothing. Once the budget is spent, `pix_adv` produces nothing until the next `line_start`. A count of 0 gives no pixels at all.
- R3: In a cycle where `line_start` is high, no pixel is produced, even if `pix_adv` is also high.
- R4: Steps k = 0 to 255 of the pattern carry the 12-bit value k on every channel.
- R5: Steps k = 256 to 495 carry the 12-bit value 3856 + (k − 256), ending at 4095 on every channel.
- R6: Steps 496 to 511 form four groups of four steps, g = 0 to 3. Within group g, channel c (0-based, lane c of the bus) holds one constant. The constants are 320/384/448/512 for g = 0, 576/640/704/768 for g = 1, 1088/1152/1216/1280 for g = 2 and 2112/2176/2240/2304 for g = 3, listed for c = 0 to 3.
- R7: After step 511 the pattern wraps to step 0 within the same line. Every `line_start`, including one that arrives mid-line, restarts all channels at step 0.
- R8: `width_sel` scales the output right-aligned in 12 bits. The value 0 or 3 gives 12-bit values, 1 gives the 12-bit value divided by 4 (10-bit), and 2 gives it divided by 16 (8-bit).
- R9: `out_mode` = 2 selects the pattern. Any other value outputs the channel's `sens_data` lane as sampled in the advancing cycle. Lane c occupies bits [12c+11:12c] of both buses.
- R10: Pixel results appear on the outputs one clock after the advancing cycle, with `pix_valid` high. While `pix_valid` is low, `pix_data` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | Start of line; loads count, restarts pattern |
| pix_adv | input | 1 | Pixel advance enable |
| width_sel | input | 2 | Output width: 0/3 = 12, 1 = 10, 2 = 8 bits |
| out_mode | input | 2 | 2 = test pattern, other values = sensor data |
| pix_count | input | CNT_W | Pixels per channel for the coming line |
| sens_data | input | NCH*12 | Sensor samples, 12 bits per channel |
| pix_data | output | NCH*12 | Output pixels, 12 bits per channel |
| pix_valid | output | 1 | Output pixel strobe |

## Verification
The hardest states to reach from the ports are the per-channel plateaus and the wrap past step 511. Both exist only after hundreds of consumed pixels. The stimulus therefore runs lines longer than 512 pixels, with periodic stalls, at each of the output widths. A second hard case is a `line_start` that coincides with a raised `pix_adv` or lands partway through a line. The stimulus cuts one line short with a new start, and always raises the advance during the start cycle. It also runs a zero-length line and keeps advancing past the budget, so that any surplus pixel would show up as an unexpected result.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  localparam int PIX_W  = 12;
  localparam int PAT_AW = 9;
  localparam logic [1:0] MODE_TEST = 2'd2;

  typedef enum logic [1:0] {
    WS_12  = 2'd0,
    WS_10  = 2'd1,
    WS_8   = 2'd2,
    WS_12B = 2'd3
  } wsel_e;

  // Pattern value in 12-bit units for step k on lane ch.
  function automatic logic [PIX_W-1:0] pat12(input logic [PAT_AW-1:0] k,
                                             input logic [1:0] ch);
    logic [PIX_W-1:0] v;
    logic [1:0] g;
    g = k[3:2];
    if (!k[8])
      v = PIX_W'(k[7:0]);
    else if (k < 9'd496)
      v = 12'd3856 + PIX_W'(k[7:0]);
    else
      v = (12'd256 << g) + 12'd64 + PIX_W'({ch, 6'b0});
    return v;
  endfunction

  function automatic logic [PIX_W-1:0] scale_pix(input logic [PIX_W-1:0] v,
                                                 input wsel_e ws);
    logic [PIX_W-1:0] r;
    case (ws)
      WS_10:   r = v >> 2;
      WS_8:    r = v >> 4;
      default: r = v;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/tpg_line_ctrl.sv
module tpg_line_ctrl #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_start,
  input  logic             adv,
  input  logic [CNT_W-1:0] pix_count,
  output logic             fire,
  output logic             valid_q
);
  logic [CNT_W-1:0] rem_q;

  // A start cycle never produces a pixel; the budget gates advances.
  assign fire = adv && !line_start && (rem_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= fire;
      if (line_start)
        rem_q <= pix_count;
      else if (fire)
        rem_q <= rem_q - 1'b1;
    end
  end
endmodule

// File: rtl/tpg_chan.sv
module tpg_chan
  import tpg_pkg::*;
#(
  parameter int CH = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_start,
  input  logic             fire,
  input  logic             test_en,
  input  wsel_e            wsel,
  input  logic [PIX_W-1:0] sens,
  output logic [PIX_W-1:0] dout
);
  localparam logic [1:0] LANE = 2'(CH % 4);

  logic [PAT_AW-1:0] idx_q;
  logic [PIX_W-1:0]  pat;

  always_comb pat = scale_pix(pat12(idx_q, LANE), wsel);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      dout  <= '0;
    end else begin
      if (line_start)
        idx_q <= '0;
      else if (fire)
        idx_q <= idx_q + 1'b1;  // 9-bit wrap gives the 512-step repeat
      if (fire)
        dout <= test_en ? pat : sens;
    end
  end
endmodule

// File: rtl/tpg_line.sv
module tpg_line
  import tpg_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int CNT_W = 14
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 line_start,
  input  logic                 pix_adv,
  input  logic [1:0]           width_sel,
  input  logic [1:0]           out_mode,
  input  logic [CNT_W-1:0]     pix_count,
  input  logic [NCH*PIX_W-1:0] sens_data,
  output logic [NCH*PIX_W-1:0] pix_data,
  output logic                 pix_valid
);
  logic  fire;
  logic  test_en;
  wsel_e wsel;

  assign test_en = (out_mode == MODE_TEST);
  assign wsel    = wsel_e'(width_sel);

  tpg_line_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .line_start(line_start),
    .adv       (pix_adv),
    .pix_count (pix_count),
    .fire      (fire),
    .valid_q   (pix_valid)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tpg_chan #(.CH(c)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .line_start(line_start),
      .fire      (fire),
      .test_en   (test_en),
      .wsel      (wsel),
      .sens      (sens_data[c*PIX_W +: PIX_W]),
      .dout      (pix_data[c*PIX_W +: PIX_W])
    );
  end
endmodule

// File: rtl/tpg_line_chk.sv
module tpg_line_chk #(
  parameter int NCH   = 4,
  parameter int CNT_W = 14
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 line_start,
  input logic                 pix_adv,
  input logic [1:0]           width_sel,
  input logic [1:0]           out_mode,
  input logic [CNT_W-1:0]     pix_count,
  input logic [NCH*12-1:0]    pix_data,
  input logic                 pix_valid
);
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q  <= '0;
      seen_q <= '0;
    end else if (line_start) begin
      len_q  <= pix_count;
      seen_q <= '0;
    end else if (pix_valid) begin
      seen_q <= seen_q + 1'b1;
    end
  end

  // R10: a result follows an advance by one clock
  p_valid_after_adv_r10: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> $past(pix_adv));

  // R3: a start cycle yields no pixel
  p_start_no_pixel_r3: assert property (@(posedge clk) disable iff (rst)
    $past(line_start) |-> !pix_valid);

  // R2: never more pixels than the loaded budget
  p_budget_r2: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && !line_start) |-> (seen_q < len_q));

  // R10: data holds between pixels
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |-> $stable(pix_data));

  for (genvar c = 0; c < NCH; c++) begin : g_rng
    // R8: 8-bit pattern output leaves the top four bits clear
    p_range8_r8: assert property (@(posedge clk) disable iff (rst)
      (pix_valid && $past(out_mode == 2'd2 && width_sel == 2'd2))
        |-> (pix_data[c*12+8 +: 4] == 4'd0));
    // R8: 10-bit pattern output leaves the top two bits clear
    p_range10_r8: assert property (@(posedge clk) disable iff (rst)
      (pix_valid && $past(out_mode == 2'd2 && width_sel == 2'd1))
        |-> (pix_data[c*12+10 +: 2] == 2'd0));
  end
endmodule

bind tpg_line tpg_line_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .line_start(line_start),
  .pix_adv   (pix_adv),
  .width_sel (width_sel),
  .out_mode  (out_mode),
  .pix_count (pix_count),
  .pix_data  (pix_data),
  .pix_valid (pix_valid)
);

// File: tb/tpg_line_test.sv
module tpg_line_test;
  localparam int NCH   = 4;
  localparam int CNT_W = 14;
  localparam int BW    = NCH * 12;

  typedef struct {
    logic [BW-1:0] d;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          line_start = 1'b0;
  logic          pix_adv = 1'b0;
  logic [1:0]    width_sel = 2'd0;
  logic [1:0]    out_mode = 2'd2;
  logic [CNT_W-1:0] pix_count = '0;
  logic [BW-1:0] sens_data = '0;
  logic [BW-1:0] pix_data;
  logic          pix_valid;

  int n_chk = 0;
  int n_bad = 0;
  int n_pushed = 0;
  int n_seen = 0;
  bit mon_on = 1'b0;
  exp_t q[$];
  logic [BW-1:0] last_d = '0;

  int plat[16] = '{320, 384, 448, 512, 576, 640, 704, 768,
                   1088, 1152, 1216, 1280, 2112, 2176, 2240, 2304};

  always #2 clk = ~clk;

  tpg_line #(.NCH(NCH), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .line_start(line_start), .pix_adv(pix_adv),
    .width_sel(width_sel), .out_mode(out_mode), .pix_count(pix_count),
    .sens_data(sens_data), .pix_data(pix_data), .pix_valid(pix_valid)
  );

  function automatic int ref_val(int k, int c, logic [1:0] ws);
    int v;
    if (k < 256)      v = k;
    else if (k < 496) v = 3856 + (k - 256);
    else              v = plat[((k - 496) / 4) * 4 + c];
    if (ws == 2'd1)      v = v / 4;
    else if (ws == 2'd2) v = v / 16;
    return v;
  endfunction

  task automatic check(bit ok, string tag, logic [BW-1:0] act, logic [BW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: starts a line (advance raised during the start cycle, R3),
  // then advances for 'cycles' cycles with optional stalls.
  task automatic drive_line(int n, logic [1:0] mode, logic [1:0] ws,
                            int stall, int cycles, string force_tag);
    int rem;
    int k;
    int num;
    @(negedge clk);
    line_start = 1'b1; pix_adv = 1'b1;
    pix_count = CNT_W'(n); out_mode = mode; width_sel = ws;
    @(negedge clk);
    line_start = 1'b0;
    rem = n; k = 0; num = 0;
    for (int i = 0; i < cycles; i++) begin
      logic [63:0] r;
      bit a;
      exp_t e;
      a = !(stall > 0 && (i % stall) == stall - 1);
      r = {$urandom(), $urandom()};
      pix_adv = a;
      sens_data = r[BW-1:0];
      if (a && rem > 0) begin
        for (int c = 0; c < NCH; c++)
          e.d[c*12 +: 12] = (mode == 2'd2) ? 12'(ref_val(k, c, ws))
                                           : r[c*12 +: 12];
        if (force_tag != "")  e.tag = force_tag;
        else if (mode != 2'd2) e.tag = "R9";
        else if (num >= 512)   e.tag = "R7";
        else if (ws != 2'd0)   e.tag = "R8";
        else if (k < 256)      e.tag = "R4";
        else if (k < 496)      e.tag = "R5";
        else                   e.tag = "R6";
        q.push_back(e);
        n_pushed++;
        k = (k + 1) % 512;
        rem--;
        num++;
      end
      @(negedge clk);
    end
    pix_adv = 1'b0;
  endtask

  task automatic settle_and_count(string tag);
    repeat (3) @(negedge clk);
    check(q.size() == 0 && n_seen == n_pushed, tag,
          BW'(n_seen), BW'(n_pushed));
  endtask

  // Monitor: samples just after each rising edge.
  always begin
    @(posedge clk);
    #1;
    if (mon_on) begin
      if (pix_valid) begin
        n_seen++;
        if (q.size() == 0) begin
          check(1'b0, "R2 surplus pixel", pix_data, '0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(pix_data == e.d, e.tag, pix_data, e.d);
        end
      end else if (pix_data != last_d) begin
        check(1'b0, "R10 hold", pix_data, last_d);
      end
      last_d = pix_data;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(pix_valid == 1'b0 && pix_data == '0, "R1 in reset", pix_data, '0);
    rst = 1'b0;
    @(posedge clk); #1;
    check(pix_valid == 1'b0 && pix_data == '0, "R1 after reset", pix_data, '0);
    last_d = pix_data;
    mon_on = 1'b1;

    drive_line(20, 2'd2, 2'd0, 0, 30, "");    // R3, R4, budget end R2
    settle_and_count("R2 short line");
    drive_line(600, 2'd2, 2'd0, 3, 950, "");  // R4..R7 with stalls
    settle_and_count("R2 stalled line");
    drive_line(520, 2'd2, 2'd1, 0, 530, "");  // R8 10-bit
    settle_and_count("R8 10-bit count");
    drive_line(520, 2'd2, 2'd2, 5, 700, "");  // R8 8-bit
    settle_and_count("R8 8-bit count");
    drive_line(515, 2'd2, 2'd3, 0, 515, "");  // R8 code 3 as 12-bit
    settle_and_count("R8 code3 count");
    drive_line(30, 2'd0, 2'd0, 4, 45, "");    // R9 pass-through
    drive_line(25, 2'd1, 2'd2, 0, 25, "");    // R9 width ignored
    settle_and_count("R9 count");
    drive_line(40, 2'd2, 2'd0, 0, 10, "");    // cut short
    drive_line(8, 2'd2, 2'd0, 0, 12, "R7 restart");
    settle_and_count("R7 restart count");
    drive_line(0, 2'd2, 2'd0, 0, 10, "");     // zero budget
    settle_and_count("R2 zero count");

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule